// File: doc/BRIEF.md
# Frame-to-Master Clock Ratio Detector

This block works out how many master-clock cycles make up one sample period when the frame clock comes from outside the chip (slave operation). In that mode it takes the place of a programmed rate selection. A two-flop synchroniser brings the frame clock into the master-clock domain. A period counter measures the gap between consecutive rising edges. When the prescale bit is set, the counter advances only on every second master clock, so it counts as if the master clock had been divided by two. A classifier compares each finished measurement against the ratios that are legal for the current prescale setting.

The decisions are made by a four-state machine. `IDLE` waits for the first frame edge, which only opens a measurement. `MEASURE` has no candidate ratio. `QUALIFY` holds a candidate ratio and counts matching periods in a row. `LOCKED` reports a confirmed ratio. The named transitions are:
- start: `IDLE`→`MEASURE` on the first edge.
- first-hit: `MEASURE`→`QUALIFY` on a matching period.
- retarget: `QUALIFY`/`LOCKED`→`QUALIFY` when a period matches a different ratio.
- confirm: `QUALIFY`→`LOCKED` on the third consecutive matching period.
- hold: `LOCKED`→`LOCKED` when the period matches the same ratio again.
- miss: `QUALIFY`/`LOCKED`→`MEASURE` when a period matches no ratio.
- overflow: `QUALIFY`/`LOCKED`→`MEASURE` as soon as the counter saturates.

Top module: `fsr_ratio_detect`

## Requirements
- R1: The frame clock passes through two synchroniser flops. A rising edge of the synchronised signal ends one period and starts the next. The first edge after reset only starts a measurement.
- R2: With `prescale_i` low, the counter advances on every master clock. With it high, the counter advances on every second master clock. A steady frame period of P master clocks measures P (prescale low) or P/2 ±1 (prescale high).
- R3: A measurement matches a ratio when it lies within ±2 counts of that ratio's target. The codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1024 and 7=1536 master clocks per sample.
- R4: With prescale low, only codes 0–3 are legal, and each target is the ratio itself. With prescale high, only codes 2–7 are legal, and each target is half the ratio.
- R5: `locked_o` rises after three consecutive matching periods that give the same code. At that point `ratio_code_o` takes that code, and it stays unchanged while lock holds.
- R6: A period that matches no legal ratio drops lock. A period that matches a different ratio drops lock and restarts qualification at one. `ratio_valid_o` is never high while `locked_o` is low.
- R7: When the counter reaches its all-ones value (4095 with the default width), lock drops on the next clock. The saturated period then matches no ratio.
- R8: `ratio_valid_o` is a one-cycle pulse that goes high together with `locked_o` on lock entry and again after every further matching period while locked.
- R9: After reset, `locked_o`, `ratio_valid_o` and `ratio_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| prescale_i | input | 1 | Count on every second master clock and use the high ratio set |
| frame_clk_i | input | 1 | Externally supplied frame clock, asynchronous |
| ratio_code_o | output | 3 | Code of the locked ratio |
| ratio_valid_o | output | 1 | Pulse on each confirmed matching period while locked |
| locked_o | output | 1 | Ratio is locked |

## Verification
The bench uses the default parameters: a 12-bit period counter, a tolerance of two counts and a lock run of three periods. With these values, both ratio sets fit within a 1536-clock frame. Saturation is reached after about 4100 master clocks with no frame edge, which keeps the dropout case short. Frame periods just inside (386) and just outside (125) the tolerance window test the match limits. A 512-clock frame is applied with each prescale setting, which tests the split between the two legal sets.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int NUM_RATIOS = 8;
    localparam int CODE_W     = $clog2(NUM_RATIOS);

    typedef logic [CODE_W-1:0] ratio_code_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_QUALIFY = 2'd2,
        ST_LOCKED  = 2'd3
    } det_state_t;

    // Master clocks per sample for a ratio code: 128 and 192 scaled by powers of two.
    function automatic int ratio_of(input int idx);
        int base;
        base = ((idx % 2) == 0) ? 128 : 192;
        return base << (idx / 2);
    endfunction

    function automatic logic within_tol(input int value, input int target, input int tol);
        int diff;
        diff = value - target;
        if (diff < 0) diff = -diff;
        return (diff <= tol);
    endfunction

endpackage

// File: rtl/fsr_frame_sync.sv
module fsr_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_i};
        end
    end

    // Synchronised level is chain_q[STAGES-1]; chain_q[STAGES] is its previous value.
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R1: two rising edges of the synchronised level cannot be adjacent
    assert_edge_spaced_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fsr_period_counter.sv
module fsr_period_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             prescale_i,
    input  logic             boundary_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             phase_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    // Half-rate phase so that a set prescale bit counts every second clock.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign tick = prescale_i ? phase_q : 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (boundary_i) begin
            cnt_q <= {{(CNT_W-1){1'b0}}, tick};
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;
    assign sat_o   = (cnt_q == CNT_MAX);

    // R7: a saturated counter stays saturated until a frame edge arrives
    assert_sat_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sat_o && !boundary_i) |=> sat_o);

    // R2: after a boundary the count restarts at zero or one
    assert_restart_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        boundary_i |=> (count_o <= 1));

endmodule

// File: rtl/fsr_ratio_classify.sv
module fsr_ratio_classify
    import fsr_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             prescale_i,
    output logic             hit_o,
    output ratio_code_t      code_o
);
    logic [NUM_RATIOS-1:0] hit_vec;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
        localparam int FULL      = ratio_of(i);
        localparam int HALF      = FULL / 2;
        localparam bit OK_DIRECT = (FULL <= 384);
        localparam bit OK_HALVED = (FULL >= 256);

        assign hit_vec[i] = prescale_i
            ? (OK_HALVED && within_tol(int'(count_i), HALF, TOL))
            : (OK_DIRECT && within_tol(int'(count_i), FULL, TOL));
    end

    always_comb begin
        code_o = '0;
        for (int k = 0; k < NUM_RATIOS; k++) begin
            if (hit_vec[k]) code_o = ratio_code_t'(k);
        end
    end

    assign hit_o = |hit_vec;

    // R3: tolerance windows never overlap, so at most one ratio matches
    always_comb begin
        assert_one_match_R3: assert ($onehot0(hit_vec));
    end

endmodule

// File: rtl/fsr_ratio_detect.sv
module fsr_ratio_detect
    import fsr_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int TOL         = 2,
    parameter int LOCK_N      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        prescale_i,
    input  logic        frame_clk_i,
    output logic [2:0]  ratio_code_o,
    output logic        ratio_valid_o,
    output logic        locked_o
);
    localparam int STREAK_W = $clog2(LOCK_N + 1);
    localparam logic [STREAK_W-1:0] STREAK_LAST = STREAK_W'(LOCK_N - 1);

    logic             edge_s;
    logic [CNT_W-1:0] count_s;
    logic             sat_s;
    logic             hit_s;
    ratio_code_t      hit_code_s;

    det_state_t          state_q, state_n;
    logic [STREAK_W-1:0] streak_q, streak_n;
    ratio_code_t         cand_q, cand_n;
    logic                confirm_s;
    logic                valid_q;
    ratio_code_t         code_q;

    fsr_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (frame_clk_i),
        .rise_o  (edge_s)
    );

    fsr_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .prescale_i (prescale_i),
        .boundary_i (edge_s),
        .count_o    (count_s),
        .sat_o      (sat_s)
    );

    fsr_ratio_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .count_i    (count_s),
        .prescale_i (prescale_i),
        .hit_o      (hit_s),
        .code_o     (hit_code_s)
    );

    // Next-state logic
    always_comb begin
        state_n   = state_q;
        streak_n  = streak_q;
        cand_n    = cand_q;
        confirm_s = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_s) state_n = ST_MEASURE;                 // start
            end
            ST_MEASURE: begin
                if (edge_s && hit_s) begin                         // first-hit
                    state_n  = ST_QUALIFY;
                    streak_n = STREAK_W'(1);
                    cand_n   = hit_code_s;
                end
            end
            ST_QUALIFY: begin
                if (edge_s) begin
                    if (!hit_s) begin                              // miss
                        state_n = ST_MEASURE;
                    end else if (hit_code_s != cand_q) begin       // retarget
                        streak_n = STREAK_W'(1);
                        cand_n   = hit_code_s;
                    end else if (streak_q == STREAK_LAST) begin    // confirm
                        state_n   = ST_LOCKED;
                        confirm_s = 1'b1;
                    end else begin
                        streak_n = streak_q + 1'b1;
                    end
                end else if (sat_s) begin                          // overflow
                    state_n = ST_MEASURE;
                end
            end
            ST_LOCKED: begin
                if (edge_s) begin
                    if (!hit_s) begin                              // miss
                        state_n = ST_MEASURE;
                    end else if (hit_code_s != cand_q) begin       // retarget
                        state_n  = ST_QUALIFY;
                        streak_n = STREAK_W'(1);
                        cand_n   = hit_code_s;
                    end else begin                                 // hold
                        confirm_s = 1'b1;
                    end
                end else if (sat_s) begin                          // overflow
                    state_n = ST_MEASURE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= ST_IDLE;
            streak_q <= '0;
            cand_q   <= '0;
        end else begin
            state_q  <= state_n;
            streak_q <= streak_n;
            cand_q   <= cand_n;
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            code_q  <= '0;
        end else begin
            valid_q <= confirm_s;
            if (confirm_s) code_q <= cand_q;
        end
    end

    assign locked_o      = (state_q == ST_LOCKED);
    assign ratio_valid_o = valid_q;
    assign ratio_code_o  = 3'(code_q);

    // R6: no valid pulse outside lock
    assert_valid_only_locked_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ratio_valid_o |-> locked_o);

    // R8: lock entry comes with a valid pulse
    assert_entry_strobe_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(locked_o) |-> ratio_valid_o);

    // R7: a saturated period with no edge removes lock on the next clock
    assert_sat_unlocks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sat_s && !edge_s) |=> !locked_o);

    // R5: the reported code does not move while lock holds
    assert_code_steady_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        locked_o |=> (!locked_o || $stable(ratio_code_o)));

    // R1: no lock can exist before a frame edge has started a measurement
    assert_idle_unlocked_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE) |-> (!locked_o && !ratio_valid_o));

endmodule

// File: tb/tb_fsr_ratio_detect.sv
module tb_fsr_ratio_detect;
    localparam int CLK_P    = 10;
    localparam int CMAX     = 4095;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps  = 1'b0;
    logic       fck = 1'b0;
    logic [2:0] code;
    logic       valid;
    logic       locked;

    int n_cmp  = 0;
    int n_bad  = 0;
    int n_cyc  = 0;
    int vpulse = 0;
    bit done   = 1'b0;

    fsr_ratio_detect dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .prescale_i    (ps),
        .frame_clk_i   (fck),
        .ratio_code_o  (code),
        .ratio_valid_o (valid),
        .locked_o      (locked)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_hist[$] = '{0, 0, 0};
    int m_cnt = 0, m_ph = 0, m_started = 0, m_streak = 0, m_cand = 0;
    int m_lock = 0, m_val = 0, m_code = 0;
    int e_b, tk, hit, sat_b, nv;
    int ratios[8] = '{128, 192, 256, 384, 512, 768, 1024, 1536};

    function automatic int classify(input int c, input int p);
        int d;
        for (int i = 0; i < 8; i++) begin
            int tgt;
            bit legal;
            legal = p ? (i >= 2) : (i <= 3);
            tgt   = p ? ratios[i] / 2 : ratios[i];
            d     = c - tgt;
            if (d < 0) d = -d;
            if (legal && d <= 2) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hist = '{0, 0, 0};
            m_cnt = 0; m_ph = 0; m_started = 0; m_streak = 0; m_cand = 0;
            m_lock = 0; m_val = 0; m_code = 0;
        end else begin
            e_b   = (m_hist[1] != 0 && m_hist[2] == 0) ? 1 : 0;
            tk    = ps ? m_ph : 1;
            hit   = classify(m_cnt, int'(ps));
            sat_b = (m_cnt == CMAX) ? 1 : 0;
            nv    = 0;
            if (m_started == 0) begin
                if (e_b != 0) m_started = 1;
            end else if (e_b != 0) begin
                if (hit < 0) begin
                    m_lock = 0; m_streak = 0;
                end else if (hit == m_cand && m_streak > 0) begin
                    if (m_lock != 0) nv = 1;
                    else if (m_streak + 1 >= 3) begin
                        m_lock = 1; nv = 1; m_code = hit;
                    end else m_streak++;
                end else begin
                    m_lock = 0; m_streak = 1; m_cand = hit;
                end
            end else if (sat_b != 0) begin
                m_lock = 0; m_streak = 0;
            end
            if (e_b != 0) m_cnt = tk;
            else if (tk != 0 && m_cnt < CMAX) m_cnt++;
            m_ph = 1 - m_ph;
            m_hist.push_front(int'(fck));
            void'(m_hist.pop_back());
            m_val = nv;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        n_cyc++;
        if (!rst && !done) begin
            chk("R5 locked vs model", int'(locked), m_lock);
            chk("R8 valid vs model", int'(valid), m_val);
            chk("R3 code vs model", int'(code), m_code);
            if (valid) vpulse++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run(input int period, input int n);
        repeat (n) begin
            @(negedge clk); fck = 1'b1;
            idle(period / 2 - 1);
            @(negedge clk); fck = 1'b0;
            idle(period - period / 2 - 1);
        end
    endtask

    initial begin
        idle(4);
        chk("R9 reset locked", int'(locked), 0);
        chk("R9 reset valid", int'(valid), 0);
        chk("R9 reset code", int'(code), 0);
        @(negedge clk); rst = 1'b0;
        idle(20);
        chk("R1 no lock before edges", int'(locked), 0);

        // R1 R5: first edge only starts, three matches needed
        run(256, 3);
        chk("R5 two matches not locked", int'(locked), 0);
        run(256, 1);
        chk("R5 locked after three", int'(locked), 1);
        chk("R2 code 256", int'(code), 2);

        // R8: one pulse per further matching period
        vpulse = 0;
        run(256, 3);
        chk("R8 pulses per period", vpulse, 3);

        // R3 R6: in-tolerance different ratio retargets
        run(386, 1);
        chk("R6 still locked before 386 measured", int'(locked), 1);
        run(386, 3);
        chk("R6 relock on new ratio", int'(locked), 1);
        chk("R3 code 384 within tol", int'(code), 3);

        // R3 R6: outside tolerance drops lock
        run(125, 2);
        chk("R6 lock dropped", int'(locked), 0);
        run(125, 2);
        chk("R3 125 not matched", int'(locked), 0);
        chk("R6 valid low unlocked", int'(valid), 0);

        // R4: 512 illegal with prescale low
        run(512, 5);
        chk("R4 512 rejected prescale low", int'(locked), 0);

        // R4 R2: prescale high set
        ps = 1'b1;
        run(512, 5);
        chk("R4 512 locked prescale high", int'(locked), 1);
        chk("R4 code 512", int'(code), 4);
        run(1536, 4);
        chk("R4 1536 locked", int'(locked), 1);
        chk("R4 code 1536", int'(code), 7);

        // R7: frame clock stops
        ps = 1'b0;
        run(256, 5);
        chk("R7 pre-stop lock", int'(locked), 1);
        idle(4300);
        chk("R7 saturation unlocks", int'(locked), 0);
        chk("R7 valid low", int'(valid), 0);
        run(256, 3);
        chk("R7 saturated period rejected", int'(locked), 0);
        run(256, 1);
        chk("R7 relock after recovery", int'(locked), 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", n_cyc, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule